// File: doc/BRIEF.md
# Framed Three-Bit Pattern Detector

This block watches a serial bit stream and groups the accepted bits into back-to-back, non-overlapping frames of three. When the third bit of a frame completes either of the two target groups, 010 or 110 (earliest bit written first), it raises a one-cycle hit. The first bit of a frame never affects the result. After the third bit, the block always starts a new frame, whether or not a hit occurred.

Each incoming bit is qualified by a valid strobe. Cycles without the strobe are ignored entirely. The hit is produced combinationally from the present state and the present bit, so it can be used in the same cycle. A registered copy, one cycle later, is also provided for consumers that need a flop-bounded signal. Frame alignment comes only from reset: a synchronous, active-low reset puts the block at the start of a frame. The state machine has four states: frame start, one bit seen, second bit was 0, and second bit was 1.

Top module: `frame_pattern_detector`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the block returns to the start of a frame, and `hit_q` reads 0 in the following cycle.
- R2: On the third valid bit of a frame, `hit` is 1 in that same cycle when the frame's second bit was 1 and the third bit (`bit_in`) is 0, i.e. the frame was 010 or 110.
- R3: For the other six frames (000, 001, 011, 100, 101, 111), `hit` stays 0 for the whole frame.
- R4: `hit` is 0 on the first and second valid bits of every frame, whatever their values.
- R5: After the third valid bit of a frame, the next valid bit is always treated as the first bit of a new frame, so consecutive frames are judged independently.
- R6: In a cycle with `bit_valid` low, `hit` is 0, and the frame position and stored bit are unchanged: the next valid bit continues the frame exactly as if the idle cycle had not occurred.
- R7: `hit_q` equals the value `hit` had in the previous cycle, except after reset, where it reads 0.
- R8: A reset applied in the middle of a frame discards the partial frame. The next valid bit starts a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_valid | input | 1 | Marks `bit_in` as a stream bit in this cycle |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | Combinational match on the third bit of a 010/110 frame |
| hit_q | output | 1 | `hit` delayed by one clock |

## Verification
The hardest condition to reach from the ports is a frame whose bits are separated by idle cycles in different positions. A mistake in the hold logic then shifts the frame boundary, yet the error shows only on a later frame. The bench covers every ordered pair of frames (64 six-bit streams). For each stream it places idle cycles before a different bit position, chosen from the stream index. The expected value for each bit comes from a frame position kept in the bench. A separate sequence applies reset after one and after two bits, to show that alignment is restored.

// File: rtl/frame_det_pkg.sv
// Package: shared types for the framed pattern detector.
// Assumes: four-state machine, binary-encoded in two bits.
package frame_det_pkg;

    localparam int STATE_W = 2;

    // Position within the current three-bit frame.
    typedef enum logic [STATE_W-1:0] {
        FS_START = 2'd0,  // waiting for bit one
        FS_GOT1  = 2'd1,  // bit one taken, its value discarded
        FS_LOW2  = 2'd2,  // bit two was 0
        FS_HIGH2 = 2'd3   // bit two was 1
    } frame_state_e;

endpackage

// File: rtl/frame_seq_fsm.sv
// Module: frame_seq_fsm
// Tracks the position in the current three-bit frame and keeps bit two.
// Assumes: rst_n is synchronous, active low; bits count only when valid.
module frame_seq_fsm
    import frame_det_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_valid,
    input  logic         bit_in,
    output frame_state_e state
);

    frame_state_e state_nx;

    // Next-state selection for one accepted bit.
    always_comb begin
        state_nx = state;
        if (bit_valid) begin
            unique case (state)
                FS_START: state_nx = FS_GOT1;
                FS_GOT1:  state_nx = bit_in ? FS_HIGH2 : FS_LOW2;
                FS_LOW2:  state_nx = FS_START;
                FS_HIGH2: state_nx = FS_START;
                default:  state_nx = FS_START;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FS_START;
        else        state <= state_nx;
    end

    // R1: reset lands in the frame start state.
    p_reset_start_r1: assert property (@(posedge clk)
        !rst_n |=> state == FS_START);

    // R6: an idle cycle leaves the frame position untouched.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(state));

    // R5: the third accepted bit always closes the frame.
    p_frame_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && (state == FS_LOW2 || state == FS_HIGH2)) |=> state == FS_START);

endmodule

// File: rtl/frame_hit_decode.sv
// Module: frame_hit_decode
// Mealy output: flags a third bit of 0 that follows a second bit of 1.
// Assumes: state comes from frame_seq_fsm in the same clock domain.
module frame_hit_decode
    import frame_det_pkg::*;
(
    input  frame_state_e state,
    input  logic         bit_valid,
    input  logic         bit_in,
    output logic         hit
);

    // Combinational match on the closing bit of the frame.
    always_comb begin
        hit = bit_valid && (state == FS_HIGH2) && !bit_in;
    end

endmodule

// File: rtl/frame_hit_reg.sv
// Module: frame_hit_reg
// Registers the match flag for users that need a flop output.
// Assumes: synchronous active-low reset clears the copy.
module frame_hit_reg #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // One-cycle delay stage.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/frame_pattern_detector.sv
// Module: frame_pattern_detector (top)
// Finds 010 or 110 in non-overlapping three-bit frames of a serial stream.
// Assumes: frames are aligned by reset; bit_valid qualifies every bit.
module frame_pattern_detector
    import frame_det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic hit,
    output logic hit_q
);

    localparam int HIT_W = 1;

    frame_state_e state;

    frame_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .state     (state)
    );

    frame_hit_decode u_dec (
        .state     (state),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .hit       (hit)
    );

    frame_hit_reg #(.WIDTH(HIT_W)) u_hreg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (hit),
        .q     (hit_q)
    );

    // R6: no match in an idle cycle.
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> !hit);

    // R4: a match is raised only when the frame is at its third bit.
    p_third_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (state == FS_LOW2 || state == FS_HIGH2));

    // R7: the registered copy trails the live flag by one cycle.
    p_copy_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> hit_q == $past(hit));

endmodule

// File: tb/frame_pattern_detector_bench.sv
// Bench: exhaustive two-frame sweep with idle gaps, plus reset cases.
module frame_pattern_detector_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic hit, hit_q;

    int checks = 0;
    int errors = 0;
    int pos = 0;           // bench's own frame position
    logic second = 1'b0;   // bench's copy of bit two
    logic prev_exp = 1'b0; // expected hit of the previous cycle

    always #5 clk = ~clk;

    frame_pattern_detector u_frame_pattern_detector (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid),
        .bit_in(bit_in), .hit(hit), .hit_q(hit_q)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle; check hit and hit_q before the rising edge.
    task automatic cycle(input logic v, input logic b);
        logic exp;
        @(negedge clk);
        bit_valid = v;
        bit_in = b;
        #1;
        exp = v && (pos == 2) && second && !b;
        if (!v)            check("R6 idle cycle hit", hit, 1'b0);
        else if (pos == 2) check(exp ? "R2 match on third bit" : "R3 no match on third bit", hit, exp);
        else               check("R4 no match on bits one/two", hit, 1'b0);
        check("R7 registered copy", hit_q, prev_exp);
        @(posedge clk);
        prev_exp = exp;
        if (v) begin
            if (pos == 1) second = b;
            pos = (pos == 2) ? 0 : pos + 1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_valid = 1'b1;
        bit_in = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        bit_valid = 1'b0;
        #1;
        check("R1 hit_q cleared by reset", hit_q, 1'b0);
        pos = 0;
        second = 1'b0;
        prev_exp = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        do_reset();
        // R2/R3/R5/R6: every pair of frames, idle gaps moving around.
        for (int s = 0; s < 64; s++) begin
            for (int k = 5; k >= 0; k--) begin
                if ((s % 7) == k) cycle(1'b0, 1'b1);
                if ((s % 5) == k) cycle(1'b0, 1'b0);
                cycle(1'b1, s[k]);
            end
        end
        // R8: reset after one bit, then 010 must match.
        cycle(1'b1, 1'b1);
        do_reset();
        cycle(1'b1, 1'b0); cycle(1'b1, 1'b1); cycle(1'b1, 1'b0);
        // R8: reset after two bits (x1), then 110 must match.
        cycle(1'b1, 1'b0); cycle(1'b1, 1'b1);
        do_reset();
        cycle(1'b1, 1'b1); cycle(1'b1, 1'b1); cycle(1'b1, 1'b0);
        cycle(1'b0, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule